// File: doc/BRIEF.md
# Tick-Driven Compare Timer

This block is a memory-mapped general-purpose timer. It has a 32-bit up-counter, one output-compare channel, a sticky compare flag that software clears by writing one, and a separate interrupt-enable register. The interrupt output is a level. Software arms an event by reading the count, adding a delta and writing the sum to the compare register. The flag and the interrupt assert when the counter lands on that value.

The counter does not run on its own clock. It advances on enable pulses that are synchronous to the block clock. One pulse source is picked from three: a bus-clock tick, a peripheral-clock tick, or an oscillator tick. The oscillator tick passes through its own small divider, and only when its path enable bit is set. The picked pulse then goes through the main prescaler.

Clearing the module enable stops the timer and resets the count and both prescalers. A wait-mode input freezes counting unless the control register allows running during wait.

Top module: `tick_compare_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The register offsets are fixed: control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compare 0x10, counter 0x24. Any other offset reads 0. Only these bits are writable and read back: control bits 0, 3, 6 to 8, 9 and 10; prescaler bits 15:0; interrupt-enable bit 0; all 32 compare bits.
- R3: The counter offset is read-only. A write to it leaves the count unchanged.
- R4: Control bits 8:6 pick the pulse source: 1 is `bus_tick`, 2 is `per_tick`, 5 is the divided oscillator path. Any other code stops the count.
- R5: Prescaler bits 11:0 hold P. The counter advances once every P+1 pulses of the selected source.
- R6: The oscillator path passes pulses only while control bit 10 is 1. Prescaler bits 15:12 hold D, and the path emits one pulse every D+1 `osc_tick` pulses.
- R7: Status bit 0 sets on the advance that makes the counter equal the compare value. It stays set until software writes 1 to status bit 0.
- R8: If the flag is set and cleared in the same cycle, the flag ends up set.
- R9: `irq` equals status bit 0 AND interrupt-enable bit 0.
- R10: With control bit 9 at 1, counting continues past a match. With bit 9 at 0, the advance after the counter equals the compare value returns it to 0.
- R11: While control bit 0 is 0, the count and both prescaler phases are held at 0.
- R12: While `cpu_wait` is high and control bit 3 is 0, the counter and both prescalers hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick | input | 1 | Bus-clock enable pulse |
| per_tick | input | 1 | Peripheral-clock enable pulse |
| osc_tick | input | 1 | Oscillator enable pulse |
| cpu_wait | input | 1 | High while the system is in wait mode |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level compare interrupt |

## Verification
Two functions can fall in the same cycle: the counter landing on the compare value sets the flag, and a software write of 1 to status bit 0 clears it. The bench provokes the collision by holding a clear write active across the cycles around a known match. The source is ticked every cycle, so the match cycle is exact. The behavioural model predicts that the flag is visible for exactly one cycle and that the clear then takes effect. Both `irq` and the status read are compared against that model on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_AW = 8;

  localparam logic [REG_AW-1:0] OFS_CTRL = 8'h00;
  localparam logic [REG_AW-1:0] OFS_PRE  = 8'h04;
  localparam logic [REG_AW-1:0] OFS_STAT = 8'h08;
  localparam logic [REG_AW-1:0] OFS_IEN  = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_CMP  = 8'h10;
  localparam logic [REG_AW-1:0] OFS_CNT  = 8'h24;

  // control field positions
  localparam int CB_EN    = 0;
  localparam int CB_WAIT  = 3;
  localparam int CB_SRC_L = 6;
  localparam int CB_FREE  = 9;
  localparam int CB_OSCEN = 10;
  localparam logic [31:0] CTRL_MASK = 32'h0000_07C9;
  localparam logic [31:0] PRE_MASK  = 32'h0000_FFFF;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_BUS  = 3'd1,
    SRC_PER  = 3'd2,
    SRC_OSC  = 3'd5
  } src_code_e;

  // value the counter takes on an advance
  function automatic logic [31:0] step_count(input logic [31:0] cur,
                                             input logic [31:0] cmp,
                                             input logic        free_run);
    if (!free_run && (cur == cmp)) step_count = 32'd0;
    else                          step_count = cur + 32'd1;
  endfunction

  // a divider phase reaches its terminal value
  function automatic logic phase_done(input int unsigned phase,
                                      input int unsigned limit);
    phase_done = (phase >= limit);
  endfunction
endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
  import tmr_pkg::*;
#(
  parameter int OPRE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [2:0]        src_sel,
  input  logic              osc_en,
  input  logic [OPRE_W-1:0] osc_div,
  input  logic              bus_tick,
  input  logic              per_tick,
  input  logic              osc_tick,
  output logic              osc_pulse,
  output logic              src_tick
);
  logic [OPRE_W-1:0] osc_ph_q;
  logic              osc_live;

  assign osc_live  = run & osc_en & osc_tick;
  assign osc_pulse = osc_live & phase_done(32'(osc_ph_q), 32'(osc_div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        osc_ph_q <= '0;
    else if (clr)      osc_ph_q <= '0;
    else if (osc_live) osc_ph_q <= osc_pulse ? '0 : osc_ph_q + 1'b1;
  end

  always_comb begin
    unique case (src_sel)
      SRC_BUS: src_tick = bus_tick;
      SRC_PER: src_tick = per_tick;
      SRC_OSC: src_tick = osc_pulse;
      default: src_tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          tick_in,
  input  logic [PW-1:0] limit,
  output logic          adv
);
  logic [PW-1:0] ph_q;
  logic          live;

  assign live = run & tick_in;
  assign adv  = live & phase_done(32'(ph_q), 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ph_q <= '0;
    else if (clr)  ph_q <= '0;
    else if (live) ph_q <= adv ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic          free_run,
  input  logic [CW-1:0] cmp,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  logic [CW-1:0] nxt;

  assign nxt = CW'(step_count(32'(cnt), 32'(cmp), free_run));
  assign hit = adv & ~clr & (nxt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= nxt;
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [CW-1:0] cnt,
  input  logic          hit,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] pre_q,
  output logic [CW-1:0] cmp_q,
  output logic          ien_q,
  output logic          flag_q,
  output logic          w1c_evt
);
  logic wr_ctrl, wr_pre, wr_ien, wr_cmp;

  assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
  assign wr_pre  = bus_we && (bus_addr == OFS_PRE);
  assign wr_ien  = bus_we && (bus_addr == OFS_IEN);
  assign wr_cmp  = bus_we && (bus_addr == OFS_CMP);
  assign w1c_evt = bus_we && (bus_addr == OFS_STAT) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      cmp_q  <= '0;
      ien_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;
      if (wr_pre)  pre_q  <= bus_wdata & PRE_MASK;
      if (wr_cmp)  cmp_q  <= bus_wdata[CW-1:0];
      if (wr_ien)  ien_q  <= bus_wdata[0];
      // a new match outranks a same-cycle clear
      flag_q <= hit | (flag_q & ~w1c_evt);
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_PRE:  bus_rdata = pre_q;
      OFS_STAT: bus_rdata = DW'(flag_q);
      OFS_IEN:  bus_rdata = DW'(ien_q);
      OFS_CMP:  bus_rdata = DW'(cmp_q);
      OFS_CNT:  bus_rdata = DW'(cnt);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int MPRE_W = 12,
  parameter int OPRE_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_tick,
  input  logic        per_tick,
  input  logic        osc_tick,
  input  logic        cpu_wait,
  input  logic [7:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int OPRE_L = MPRE_W;
  localparam int OPRE_H = MPRE_W + OPRE_W - 1;

  logic [31:0]       ctrl_q, pre_q;
  logic [CNT_W-1:0]  cmp_q, cnt;
  logic              ien_q, stat_flag, w1c_evt;
  logic              ctrl_en, wait_run, free_run, osc_en, run, clr;
  logic [2:0]        src_sel;
  logic              osc_pulse, src_tick, adv, hit;

  assign ctrl_en  = ctrl_q[CB_EN];
  assign wait_run = ctrl_q[CB_WAIT];
  assign free_run = ctrl_q[CB_FREE];
  assign osc_en   = ctrl_q[CB_OSCEN];
  assign src_sel  = ctrl_q[CB_SRC_L +: 3];
  assign clr      = ~ctrl_en;
  assign run      = ctrl_en & ~(cpu_wait & ~wait_run);

  tmr_regs #(.AW(8), .DW(32), .CW(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cnt(cnt), .hit(hit),
    .ctrl_q(ctrl_q), .pre_q(pre_q), .cmp_q(cmp_q), .ien_q(ien_q),
    .flag_q(stat_flag), .w1c_evt(w1c_evt)
  );

  tmr_src_sel #(.OPRE_W(OPRE_W)) u_src (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run),
    .src_sel(src_sel), .osc_en(osc_en), .osc_div(pre_q[OPRE_H:OPRE_L]),
    .bus_tick(bus_tick), .per_tick(per_tick), .osc_tick(osc_tick),
    .osc_pulse(osc_pulse), .src_tick(src_tick)
  );

  tmr_prescaler #(.PW(MPRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(run),
    .tick_in(src_tick), .limit(pre_q[MPRE_W-1:0]), .adv(adv)
  );

  tmr_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv),
    .free_run(free_run), .cmp(cmp_q), .cnt(cnt), .hit(hit)
  );

  assign irq = stat_flag & ien_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctrl_en,
  input logic          run,
  input logic          cpu_wait,
  input logic          wait_run,
  input logic          free_run,
  input logic          src_tick,
  input logic          adv,
  input logic          hit,
  input logic          w1c_evt,
  input logic          stat_flag,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp
);
  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (cnt == '0)); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !adv) |=> (cnt == $past(cnt))); // R5
  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && adv && free_run) |=> (cnt == CW'($past(cnt) + 1'b1))); // R10
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && adv && !free_run && (cnt == cmp)) |=> (cnt == '0)); // R10
  AST_ADV_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (src_tick && run)); // R5
  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wait && !wait_run) |-> !adv); // R12
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stat_flag); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_evt && !hit) |=> !stat_flag); // R7
endmodule

bind tick_compare_timer tmr_checker #(.CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .run(run),
  .cpu_wait(cpu_wait), .wait_run(wait_run), .free_run(free_run),
  .src_tick(src_tick), .adv(adv), .hit(hit), .w1c_evt(w1c_evt),
  .stat_flag(stat_flag), .cnt(cnt), .cmp(cmp_q)
);

// File: tb/tick_compare_timer_tb.sv
module tick_compare_timer_tb;
  localparam logic [7:0] A_CTRL = 8'h00, A_PRE = 8'h04, A_STAT = 8'h08,
                         A_IEN = 8'h0C, A_CMP = 8'h10, A_CNT = 8'h24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_tick = 0, per_tick = 0, osc_tick = 0, cpu_wait = 0;
  logic [7:0]  bus_addr = A_CNT;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        irq;

  int total = 0, bad = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  tick_compare_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .per_tick(per_tick),
    .osc_tick(osc_tick), .cpu_wait(cpu_wait), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference state
  logic [31:0] m_ctrl, m_pre, m_cmp, m_cnt;
  logic        m_ien, m_flag;
  int unsigned m_osc, m_psc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_pre = 0; m_cmp = 0; m_cnt = 0;
      m_ien = 0; m_flag = 0; m_osc = 0; m_psc = 0;
    end else begin
      bit go, pulse, step, set_f;
      logic [31:0] nc;
      go = m_ctrl[0] && !(cpu_wait && !m_ctrl[3]);
      pulse = 0; step = 0; set_f = 0;
      if (!m_ctrl[0]) begin
        m_osc = 0; m_psc = 0; m_cnt = 0;
      end else if (go) begin
        bit opulse;
        opulse = 0;
        if (m_ctrl[10] && osc_tick) begin
          if (m_osc >= int'(m_pre[15:12])) begin m_osc = 0; opulse = 1; end
          else m_osc++;
        end
        case (m_ctrl[8:6])
          3'd1: pulse = bus_tick;
          3'd2: pulse = per_tick;
          3'd5: pulse = opulse;
          default: pulse = 0;
        endcase
        if (pulse) begin
          if (m_psc >= int'(m_pre[11:0])) begin m_psc = 0; step = 1; end
          else m_psc++;
        end
        if (step) begin
          nc = (!m_ctrl[9] && m_cnt == m_cmp) ? 32'd0 : m_cnt + 1;
          set_f = (nc == m_cmp);
          m_cnt = nc;
        end
      end
      m_flag = set_f || (m_flag && !(bus_we && bus_addr == A_STAT && bus_wdata[0]));
      if (bus_we) begin
        case (bus_addr)
          A_CTRL: m_ctrl = bus_wdata & 32'h7C9;
          A_PRE:  m_pre  = bus_wdata & 32'hFFFF;
          A_IEN:  m_ien  = bus_wdata[0];
          A_CMP:  m_cmp  = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      A_CTRL: return m_ctrl;
      A_PRE:  return m_pre;
      A_STAT: return {31'd0, m_flag};
      A_IEN:  return {31'd0, m_ien};
      A_CMP:  return m_cmp;
      A_CNT:  return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  // advance one clock and compare at the falling edge
  task automatic cyc();
    @(negedge clk);
    if (rst_n) begin
      total++;
      if (bus_rdata !== m_read(bus_addr)) begin
        bad++;
        $display("FAIL %s rdata@%h actual=%h expected=%h", cur_req, bus_addr,
                 bus_rdata, m_read(bus_addr));
      end
      total++;
      if (irq !== (m_flag & m_ien)) begin
        bad++;
        $display("FAIL %s irq actual=%b expected=%b", cur_req, irq, m_flag & m_ien);
      end
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1; bus_wdata = d;
    cyc();
    bus_we = 0; bus_addr = A_CNT;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_addr = a; cyc(); bus_addr = A_CNT;
  endtask

  task automatic run_ticks(input int n, input int bmod, input int pmod, input int omod);
    for (int i = 0; i < n; i++) begin
      bus_tick = (bmod > 0) && (i % bmod == 0);
      per_tick = (pmod > 0) && (i % pmod == 0);
      osc_tick = (omod > 0) && (i % omod == 0);
      cyc();
    end
    bus_tick = 0; per_tick = 0; osc_tick = 0;
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values
    cur_req = "R1";
    rd(A_CTRL); rd(A_PRE); rd(A_STAT); rd(A_IEN); rd(A_CMP); rd(A_CNT);
    // R2: field masks and offsets
    cur_req = "R2";
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL);
    wr(A_CTRL, 32'h0); wr(A_PRE, 32'hFFFF_FFFF); rd(A_PRE);
    wr(A_IEN, 32'hFFFF_FFFE); rd(A_IEN); wr(A_CMP, 32'hA5A5_5A5A); rd(A_CMP);
    rd(8'h18); rd(8'h0E);
    wr(A_PRE, 0); wr(A_CMP, 32'hFFFF_0000);
    // R4: source selection
    cur_req = "R4";
    wr(A_CTRL, 32'h241);               // enable, bus source, free-run
    run_ticks(20, 2, 3, 1);
    wr(A_CTRL, 32'h281);               // peripheral source
    run_ticks(20, 1, 3, 1);
    wr(A_CTRL, 32'h341);               // oscillator path, its enable off
    run_ticks(10, 1, 1, 1);
    wr(A_CTRL, 32'h2C1);               // unused code 3
    run_ticks(10, 1, 1, 1);
    // R3: counter offset ignores writes
    cur_req = "R3";
    wr(A_CTRL, 32'h241); run_ticks(5, 1, 0, 0);
    wr(A_CNT, 32'h1234_5678); rd(A_CNT);
    // R5: main prescaler
    cur_req = "R5";
    wr(A_PRE, 3); run_ticks(25, 1, 0, 0);
    wr(A_PRE, 32'h0000_0001); run_ticks(12, 2, 0, 0);
    // R6: oscillator divider
    cur_req = "R6";
    wr(A_CTRL, 0); wr(A_PRE, 32'h0000_2001);
    wr(A_CTRL, 32'h741); run_ticks(40, 0, 0, 1);
    wr(A_PRE, 32'h0000_7000); run_ticks(40, 0, 0, 2);
    // R7 / R9: flag set, masking and clearing
    cur_req = "R7";
    wr(A_CTRL, 0); wr(A_PRE, 0); wr(A_IEN, 0); wr(A_CMP, 8);
    wr(A_CTRL, 32'h241); run_ticks(12, 1, 0, 0); rd(A_STAT);
    cur_req = "R9";
    wr(A_IEN, 1); rd(A_STAT); wr(A_IEN, 0); rd(A_IEN); wr(A_IEN, 1);
    cur_req = "R7";
    wr(A_STAT, 0); rd(A_STAT); wr(A_STAT, 1); rd(A_STAT);
    // R10: restart mode
    cur_req = "R10";
    wr(A_CTRL, 0); wr(A_CMP, 4); wr(A_CTRL, 32'h041);
    run_ticks(20, 1, 0, 0); wr(A_STAT, 1);
    wr(A_CTRL, 32'h241); run_ticks(8, 1, 0, 0);
    // R8: set and clear collide; match falls on the 6th advance
    cur_req = "R8";
    wr(A_CTRL, 0); wr(A_STAT, 1); wr(A_CMP, 6); wr(A_CTRL, 32'h241);
    bus_addr = A_STAT; bus_we = 1; bus_wdata = 1; bus_tick = 1;
    for (int i = 0; i < 10; i++) cyc();
    bus_we = 0; bus_tick = 0; bus_addr = A_CNT; rd(A_STAT);
    // R11: disable resets the count and prescaler phases
    cur_req = "R11";
    wr(A_PRE, 2); run_ticks(5, 1, 0, 0);
    wr(A_CTRL, 0); rd(A_CNT); run_ticks(4, 1, 0, 0);
    wr(A_CTRL, 32'h241); run_ticks(7, 1, 0, 0);
    // R12: wait mode
    cur_req = "R12";
    cpu_wait = 1; run_ticks(9, 1, 0, 0);
    wr(A_CTRL, 32'h249); run_ticks(9, 1, 0, 0);
    cpu_wait = 0; run_ticks(4, 1, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule